// File: doc/BRIEF.md
# Transmit Buffer Space Tracker

This block keeps the free-space count for the ring buffer of a single asynchronous transmit channel. Each packet handed to the channel deducts its byte count from the free space, and that byte count is also kept in a small queue. A slot in the queue is picked by a packet counter. The hardware that drains the ring exposes a read-packet counter. On each space query the block walks its local read counter forward to that value. For every step it adds the stored size of the packet that was consumed back to the free space. It then reports the free space. If the queue of outstanding packets is full, it reports zero instead.

The controller is a four-state machine. `ST_OFF` is the state out of reset: nothing has been initialised, enqueues are refused and queries are ignored. `ST_IDLE` is the ready state: enqueues are accepted, and a query takes the transition *query-start* into `ST_SCAN`, latching the hardware counter as the replay target. `ST_SCAN` returns one queue entry per clock. When the masked local read counter equals the target, the transition *caught-up* leads to `ST_DONE`. `ST_DONE` holds the valid flag for exactly one cycle and then takes *report-end* back to `ST_IDLE`. An init pulse takes the transition *reinit* from any state to `ST_IDLE`.

Top module: `tx_credit_tracker`

## Requirements
- R1: After reset `enq_ready_o` and `space_valid_o` are 0. Until the first init, a query never raises `space_valid_o`.
- R2: An init pulse loads the free space with `init_size_i` and sets both local packet counters to `init_rdcnt_i`. A following query with `hw_rdcnt_i` equal to `init_rdcnt_i` reports `init_size_i`.
- R3: While idle, `enq_ready_o` is 1. An accepted enqueue subtracts `enq_size_i` from the free space and advances the write counter by one.
- R4: A query returns the stored sizes of all packets between the local read counter and `hw_rdcnt_i`, oldest first. It then reports the resulting free space on `space_o`.
- R5: The replay returns one entry per clock. When k entries are returned, `space_valid_o` rises k+1 clock edges after the edge that samples `query_i` and stays high for exactly one cycle.
- R6: When the write counter minus the read counter is 15 or more (the queue mask), `space_o` reports 0. At 14 outstanding it reports the true free space.
- R7: During a replay and its report cycle, `enq_ready_o` is 0, and an offered enqueue has no effect on the free space.
- R8: Queue slots are the counters ANDed with 15 (16 slots). Replay wraps correctly from slot 15 to slot 0.
- R9: The replay target is the value of `hw_rdcnt_i` at the edge that samples the query. Later changes during the same replay do not affect that report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Initialise pulse |
| init_size_i | input | 16 | Total ring buffer size loaded on init |
| init_rdcnt_i | input | 4 | Hardware read counter value at init |
| enq_valid_i | input | 1 | Enqueue request |
| enq_size_i | input | 16 | Byte count of the enqueued packet |
| enq_ready_o | output | 1 | Enqueue accepted this cycle when high with valid |
| hw_rdcnt_i | input | 4 | Hardware read-packet counter |
| query_i | input | 1 | Space query request |
| space_valid_o | output | 1 | One-cycle flag: space_o is valid |
| space_o | output | 16 | Reported free space |

## Verification
The hardest case to reach from the ports is a full queue. It requires fifteen outstanding packets that the hardware counter has not yet consumed, and then a drop back to fourteen by moving the counter by exactly one. The stimulus starts the counters at slot 14 so that an ordinary sequence crosses the wrap from slot 15 to 0. Separate directed queries change the hardware counter, and offer an enqueue, while a replay is running. A later query then shows whether either of them leaked into the result.

// File: rtl/txcr_pkg.sv
package txcr_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_SCAN = 2'd2,
        ST_DONE = 2'd3
    } txcr_state_e;
endpackage

// File: rtl/txcr_fsm.sv
module txcr_fsm
    import txcr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic init_i,
    input  logic query_i,
    input  logic caught_i,
    output logic enq_ready_o,
    output logic capture_o,
    output logic scan_step_o,
    output logic report_o
);
    txcr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (init_i) begin
            state_d = ST_IDLE;                       // reinit
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_OFF;
                ST_IDLE: if (query_i) state_d = ST_SCAN;    // query-start
                ST_SCAN: if (caught_i) state_d = ST_DONE;   // caught-up
                ST_DONE: state_d = ST_IDLE;                 // report-end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        enq_ready_o = (state_q == ST_IDLE) && !init_i;
        capture_o   = (state_q == ST_IDLE) && query_i && !init_i;
        scan_step_o = (state_q == ST_SCAN) && !caught_i && !init_i;
        report_o    = (state_q == ST_DONE);
    end

    assert_report_once_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_DONE) |=> (state_q != ST_DONE));

    assert_scan_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SCAN && !init_i) |=> (state_q == ST_SCAN || state_q == ST_DONE));
endmodule

// File: rtl/txcr_size_queue.sv
module txcr_size_queue #(
    parameter int IDX_W   = 4,
    parameter int SPACE_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   wr_idx_i,
    input  logic [SPACE_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [SPACE_W-1:0] rd_data_o
);
    localparam int DEPTH = 2 ** IDX_W;

    logic [SPACE_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en_i) begin
            slot_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/txcr_credit_dp.sv
module txcr_credit_dp #(
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 16,
    parameter int SPACE_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               init_i,
    input  logic [SPACE_W-1:0] init_size_i,
    input  logic [IDX_W-1:0]   init_rdcnt_i,
    input  logic               enq_fire_i,
    input  logic [SPACE_W-1:0] enq_size_i,
    input  logic               capture_i,
    input  logic [IDX_W-1:0]   hw_rdcnt_i,
    input  logic               scan_step_i,
    input  logic [SPACE_W-1:0] ret_size_i,
    output logic [IDX_W-1:0]   wr_idx_o,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic               caught_o,
    output logic [SPACE_W-1:0] space_o
);
    localparam int                 MASK     = 2 ** IDX_W - 1;
    localparam logic [CNT_W-1:0]   FULL_LVL = CNT_W'(MASK);
    localparam logic [CNT_W-1:0]   ONE      = CNT_W'(1);

    logic [SPACE_W-1:0] free_q;
    logic [CNT_W-1:0]   wr_q, rd_q;
    logic [IDX_W-1:0]   tgt_q;
    logic [CNT_W-1:0]   pending;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            free_q <= '0;
            wr_q   <= '0;
            rd_q   <= '0;
            tgt_q  <= '0;
        end else if (init_i) begin
            free_q <= init_size_i;
            wr_q   <= CNT_W'(init_rdcnt_i);
            rd_q   <= CNT_W'(init_rdcnt_i);
            tgt_q  <= init_rdcnt_i;
        end else begin
            if (enq_fire_i) begin
                free_q <= free_q - enq_size_i;
                wr_q   <= wr_q + ONE;
            end else if (scan_step_i) begin
                free_q <= free_q + ret_size_i;
                rd_q   <= rd_q + ONE;
            end
            if (capture_i) tgt_q <= hw_rdcnt_i;
        end
    end

    assign wr_idx_o = wr_q[IDX_W-1:0];
    assign rd_idx_o = rd_q[IDX_W-1:0];
    assign caught_o = (rd_q[IDX_W-1:0] == tgt_q);
    assign pending  = wr_q - rd_q;
    assign space_o  = (pending >= FULL_LVL) ? '0 : free_q;

    assert_init_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_i |=> (rd_q == wr_q && free_q == $past(init_size_i)));

    assert_enq_deduct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enq_fire_i && !init_i) |=> (free_q == $past(free_q) - $past(enq_size_i)
                                     && wr_q == $past(wr_q) + ONE));

    assert_step_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scan_step_i && !enq_fire_i && !init_i) |=> (rd_q == $past(rd_q) + ONE));
endmodule

// File: rtl/tx_credit_tracker.sv
module tx_credit_tracker #(
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 16,
    parameter int SPACE_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               init_i,
    input  logic [SPACE_W-1:0] init_size_i,
    input  logic [IDX_W-1:0]   init_rdcnt_i,
    input  logic               enq_valid_i,
    input  logic [SPACE_W-1:0] enq_size_i,
    output logic               enq_ready_o,
    input  logic [IDX_W-1:0]   hw_rdcnt_i,
    input  logic               query_i,
    output logic               space_valid_o,
    output logic [SPACE_W-1:0] space_o
);
    logic               capture, scan_step, caught, enq_fire, report;
    logic [IDX_W-1:0]   wr_idx, rd_idx;
    logic [SPACE_W-1:0] ret_size, space_raw;

    txcr_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .init_i      (init_i),
        .query_i     (query_i),
        .caught_i    (caught),
        .enq_ready_o (enq_ready_o),
        .capture_o   (capture),
        .scan_step_o (scan_step),
        .report_o    (report)
    );

    assign enq_fire = enq_valid_i && enq_ready_o;

    txcr_size_queue #(.IDX_W(IDX_W), .SPACE_W(SPACE_W)) u_queue (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (enq_fire),
        .wr_idx_i  (wr_idx),
        .wr_data_i (enq_size_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (ret_size)
    );

    txcr_credit_dp #(.IDX_W(IDX_W), .CNT_W(CNT_W), .SPACE_W(SPACE_W)) u_dp (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .init_i       (init_i),
        .init_size_i  (init_size_i),
        .init_rdcnt_i (init_rdcnt_i),
        .enq_fire_i   (enq_fire),
        .enq_size_i   (enq_size_i),
        .capture_i    (capture),
        .hw_rdcnt_i   (hw_rdcnt_i),
        .scan_step_i  (scan_step),
        .ret_size_i   (ret_size),
        .wr_idx_o     (wr_idx),
        .rd_idx_o     (rd_idx),
        .caught_o     (caught),
        .space_o      (space_raw)
    );

    assign space_valid_o = report;
    assign space_o       = report ? space_raw : '0;

    assert_no_enq_in_replay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        space_valid_o |-> $past(!enq_ready_o));
endmodule

// File: tb/tx_credit_tracker_tb_top.sv
module tx_credit_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b0;
    logic [15:0] init_size = '0;
    logic [3:0]  init_cnt = '0;
    logic        enq_valid = 1'b0;
    logic [15:0] enq_size = '0;
    logic        enq_ready;
    logic [3:0]  hw_cnt = '0;
    logic        query = 1'b0;
    logic        sp_valid;
    logic [15:0] space;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    tx_credit_tracker dut_i (
        .clk_i(clk), .rst_ni(rst_n), .init_i(init), .init_size_i(init_size),
        .init_rdcnt_i(init_cnt), .enq_valid_i(enq_valid), .enq_size_i(enq_size),
        .enq_ready_o(enq_ready), .hw_rdcnt_i(hw_cnt), .query_i(query),
        .space_valid_o(sp_valid), .space_o(space)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_init(input logic [15:0] sz, input logic [3:0] cnt);
        @(negedge clk);
        init = 1'b1; init_size = sz; init_cnt = cnt; hw_cnt = cnt;
        @(posedge clk);
        @(negedge clk);
        init = 1'b0;
    endtask

    task automatic do_enq(input logic [15:0] sz);
        @(negedge clk);
        enq_valid = 1'b1; enq_size = sz;
        check(enq_ready, 1, "R3 ready while idle");
        @(posedge clk);
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    // poke: after the query edge move hw counter to hw_mid and offer an enqueue
    task automatic do_query(input logic [3:0] hw, input bit poke, input logic [3:0] hw_mid,
                            input logic [15:0] exp, input int k, input string tag);
        int n;
        @(negedge clk);
        hw_cnt = hw; query = 1'b1;
        @(posedge clk);
        @(negedge clk);
        query = 1'b0;
        if (poke) begin
            hw_cnt = hw_mid; enq_valid = 1'b1; enq_size = 16'd77;
        end
        n = 0;
        while (!sp_valid && n < 100) begin
            if (poke) check(enq_ready, 0, "R7 ready low in replay");
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        if (poke) check(enq_ready, 0, "R7 ready low in report");
        enq_valid = 1'b0;
        check(space, exp, tag);
        check(n, k + 1, {tag, " R5 latency"});
        @(posedge clk);
        @(negedge clk);
        check(sp_valid, 0, "R5 single-cycle valid");
    endtask

    // op: 0 init (val=size, hw=start), 1 enqueue (val=size), 2 query (hw, exp)
    localparam int NVEC = 11;
    localparam logic [37:0] VEC [NVEC] = '{
        {2'd0, 16'd1000, 4'd14, 16'd0},
        {2'd2, 16'd0,    4'd14, 16'd1000},  // R2
        {2'd1, 16'd100,  4'd14, 16'd0},
        {2'd1, 16'd200,  4'd14, 16'd0},
        {2'd1, 16'd300,  4'd14, 16'd0},
        {2'd2, 16'd0,    4'd14, 16'd400},   // R3
        {2'd2, 16'd0,    4'd15, 16'd500},   // R4
        {2'd2, 16'd0,    4'd1,  16'd1000},  // R8 wrap
        {2'd1, 16'd50,   4'd1,  16'd0},
        {2'd2, 16'd0,    4'd1,  16'd950},
        {2'd2, 16'd0,    4'd2,  16'd1000}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] prev_hw;
        prev_hw = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(enq_ready, 0, "R1 ready after reset");
        check(sp_valid, 0, "R1 valid after reset");
        rst_n = 1'b1;
        @(negedge clk);
        query = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(sp_valid, 0, "R1 query ignored before init");
        end
        query = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [15:0] val, exp;
            logic [3:0] hw;
            {op, val, hw, exp} = VEC[i];
            if (op == 2'd0) begin
                do_init(val, hw); prev_hw = hw;
            end else if (op == 2'd1) begin
                do_enq(val);
            end else begin
                do_query(hw, 1'b0, hw, exp, int'(4'(hw - prev_hw)), $sformatf("R2/R3/R4/R8 vec%0d", i));
                prev_hw = hw;
            end
        end

        // R6: full queue
        do_init(16'd2000, 4'd0);
        for (int i = 0; i < 14; i++) do_enq(16'd10);
        do_query(4'd0, 1'b0, 4'd0, 16'd1860, 0, "R6 fourteen outstanding");
        do_enq(16'd10);
        do_query(4'd0, 1'b0, 4'd0, 16'd0, 0, "R6 fifteen outstanding");
        do_query(4'd1, 1'b0, 4'd1, 16'd1860, 1, "R6 back to fourteen");

        // R7: enqueue offered during replay is ignored
        do_init(16'd500, 4'd0);
        for (int i = 0; i < 5; i++) do_enq(16'd10);
        do_query(4'd5, 1'b1, 4'd5, 16'd500, 5, "R7 replay result");
        do_query(4'd5, 1'b0, 4'd5, 16'd500, 0, "R7 no enqueue taken");

        // R9: target latched at the query edge
        do_init(16'd300, 4'd0);
        for (int i = 0; i < 3; i++) do_enq(16'd10);
        do_query(4'd1, 1'b1, 4'd3, 16'd280, 1, "R9 latched target");
        do_query(4'd3, 1'b0, 4'd3, 16'd300, 2, "R9 later query");

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule